// File: doc/BRIEF.md
# Adjacent-Pair Correcting Memory Codec with Spare-Column Check Bit

This block protects a 16-bit memory word with seven check bits. It corrects any one flipped bit, and it also corrects any two flipped bits that sit next to each other in the physical order of the stored word. Encoder and decoder are purely combinational. A memory wrapper places the 23-bit codeword in the array. When the memory still has an unused spare column after repair, the wrapper places one more check bit in that column.

The decoder forms the syndrome. It compares the syndrome with every single-bit column pattern and with the XOR of every pair of neighbouring columns. It then flips the matching bit or pair of bits. A repair-status input says whether the spare column was consumed by repair. While the spare column is free, the eighth syndrome bit takes part in every comparison. Many non-adjacent double errors that would otherwise look like a neighbouring pair then match nothing, and the decoder reports them as uncorrectable instead of damaging the word. When the spare column is taken, the eighth bit is ignored and the decoder still works as a complete adjacent-pair corrector.

Top module: `sdaec_codec`

## Requirements
- R1: Codeword bit p (0..15) is data bit p, and bit 16+j is check bit j. Check bit j is the XOR of the data bits selected by mask j. The masks for j = 0..6 are 0xC429, 0x2C91, 0x9263, 0x095A, 0xD986, 0x3334 and 0x66CC. The spare bit is the XOR of the odd-numbered data bits and check bits 1, 3 and 5. Decoding an unaltered codeword returns the data with all three flags low.
- R2: Any single flipped bit among the 23 codeword bits is corrected. Only the single-corrected flag is raised.
- R3: Any two flipped neighbouring bits p and p+1 (p = 0..21) are corrected. This includes the pair that spans data bit 15 and check bit 0. Only the pair-corrected flag is raised.
- R4: With the spare column free, a flipped spare bit raises only the single-corrected flag and leaves the data unchanged.
- R5: With the spare column used for repair, the spare input has no effect on any output.
- R6: With the spare column free, a non-adjacent double error whose syndrome matches no pattern raises the uncorrectable flag. The data is then passed through uncorrected.
- R7: In both modes, a non-adjacent double error never leaves all three flags low.
- R8: For the default matrix, fewer non-adjacent double errors are miscorrected with the spare column free than with it used for repair. Some are miscorrected in repair mode.
- R9: At most one single-bit, neighbouring-pair or spare pattern matches the syndrome at any time.
- R10: At most one flag is high at a time. A zero syndrome gives all flags low.
- R11: Whenever the uncorrectable flag is high, the output data equals the received data bits. The output differs from the received data in at most one bit under the single-corrected flag and at most two under the pair-corrected flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| enc_data_i | input | 16 | Data word to encode |
| enc_check_o | output | 7 | Check bits for enc_data_i |
| enc_spare_o | output | 1 | Extra check bit for the spare column |
| dec_code_i | input | 23 | Received codeword, data in bits 15:0, check bits in 22:16 |
| dec_spare_i | input | 1 | Received spare-column check bit |
| spare_used_i | input | 1 | High when the spare column was consumed by repair |
| dec_data_o | output | 16 | Corrected data word |
| dec_single_o | output | 1 | A single-bit error was corrected |
| dec_pair_o | output | 1 | A neighbouring two-bit error was corrected |
| dec_uncorr_o | output | 1 | Nonzero syndrome with no matching pattern |

## Verification
The bench builds the block with its default 16-bit data word, seven-row base matrix and alternating extra row. That configuration is small enough to apply every single error, every neighbouring pair and all 231 non-adjacent pairs. It does so on four data words, once with the spare column free and once with it taken. Because every non-adjacent pair is exercised, the miscorrection totals of the two modes can be counted exactly and compared. The spare input is toggled on each error pattern in repair mode to show it is ignored.

// File: rtl/sdaec_pkg.sv
`timescale 1ns/1ps
// Package: shared sizes and the default parity-check matrix of the codec.
// Assumes: the codeword is laid out data first, then check bits, and the
// base matrix has one unit column per check bit.
package sdaec_pkg;

    localparam int DATA_W = 16;
    localparam int CHK_W  = 7;
    localparam int CODE_W = DATA_W + CHK_W;
    localparam int SYN_W  = CHK_W + 1;

    // Data part of each base row. Every data column has weight three, so
    // single syndromes are odd and neighbour-pair syndromes are even.
    localparam logic [CHK_W-1:0][DATA_W-1:0] H_DATA_DEF = {
        16'h66CC,   // row 6
        16'h3334,   // row 5
        16'hD986,   // row 4
        16'h095A,   // row 3
        16'h9263,   // row 2
        16'h2C91,   // row 1
        16'hC429    // row 0
    };

    // Extra row held in the spare column: it selects odd codeword positions,
    // so every neighbour pair has extra syndrome bit one.
    localparam logic [CODE_W-1:0] EXT_ROW_DEF = 23'h2AAAAA;

endpackage

// File: rtl/sdaec_encoder.sv
`timescale 1ns/1ps
// Module: sdaec_encoder
// Forms the base check bits and the spare-column check bit of a data word.
// Assumes: check bit j has a unit column at codeword position DATA_W + j.
module sdaec_encoder #(
    parameter int DATA_W = sdaec_pkg::DATA_W,
    parameter int CHK_W  = sdaec_pkg::CHK_W,
    parameter logic [CHK_W-1:0][DATA_W-1:0] H_DATA = sdaec_pkg::H_DATA_DEF,
    parameter logic [DATA_W+CHK_W-1:0]      EXT_ROW = sdaec_pkg::EXT_ROW_DEF
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o,
    output logic              spare_o
);

    // One parity tree per base row over the selected data bits.
    for (genvar r = 0; r < CHK_W; r++) begin : g_row
        assign chk_o[r] = ^(data_i & H_DATA[r]);
    end

    // The extra row spans data and base check bits of the full codeword.
    assign spare_o = ^({chk_o, data_i} & EXT_ROW);

endmodule

// File: rtl/sdaec_syndrome.sv
`timescale 1ns/1ps
// Module: sdaec_syndrome
// Recomputes every row of the extended matrix over a received codeword.
// Assumes: the top syndrome bit belongs to the spare-column row; gating it
// is left to the pattern matcher.
module sdaec_syndrome #(
    parameter int DATA_W = sdaec_pkg::DATA_W,
    parameter int CHK_W  = sdaec_pkg::CHK_W,
    parameter logic [CHK_W-1:0][DATA_W-1:0] H_DATA = sdaec_pkg::H_DATA_DEF,
    parameter logic [DATA_W+CHK_W-1:0]      EXT_ROW = sdaec_pkg::EXT_ROW_DEF
) (
    input  logic [DATA_W+CHK_W-1:0] code_i,
    input  logic                    spare_i,
    output logic [CHK_W:0]          syn_o
);

    // Base rows: parity over data mask XOR the stored check bit.
    for (genvar r = 0; r < CHK_W; r++) begin : g_row
        assign syn_o[r] = ^(code_i[DATA_W-1:0] & H_DATA[r]) ^ code_i[DATA_W+r];
    end

    // Extra row: parity over the codeword XOR the spare-column bit.
    assign syn_o[CHK_W] = ^(code_i & EXT_ROW) ^ spare_i;

endmodule

// File: rtl/sdaec_matcher.sv
`timescale 1ns/1ps
// Module: sdaec_matcher
// Compares the syndrome with every column, every neighbour-column XOR and
// the spare-bit column, under a mask that drops the extra row when the spare
// column is not available.
// Assumes: the matrix meets the uniqueness rules, so at most one hit.
module sdaec_matcher #(
    parameter int DATA_W = sdaec_pkg::DATA_W,
    parameter int CHK_W  = sdaec_pkg::CHK_W,
    parameter logic [CHK_W-1:0][DATA_W-1:0] H_DATA = sdaec_pkg::H_DATA_DEF,
    parameter logic [DATA_W+CHK_W-1:0]      EXT_ROW = sdaec_pkg::EXT_ROW_DEF
) (
    input  logic [CHK_W:0]           syn_i,
    input  logic                     ext_en_i,
    output logic [DATA_W+CHK_W-1:0]  single_hit_o,
    output logic [DATA_W+CHK_W-2:0]  pair_hit_o,
    output logic                     spare_hit_o,
    output logic                     syn_nz_o
);

    localparam int CODE_W = DATA_W + CHK_W;
    localparam int SYN_W  = CHK_W + 1;
    localparam logic [SYN_W-1:0] SPARE_COL = SYN_W'(1) << CHK_W;

    // Extended column of codeword position j, built from the row parameters.
    function automatic logic [SYN_W-1:0] column(input int j);
        logic [SYN_W-1:0] c;
        c = '0;
        for (int r = 0; r < CHK_W; r++) begin
            if (j < DATA_W) c[r] = H_DATA[r][j];
            else            c[r] = ((j - DATA_W) == r);
        end
        c[CHK_W] = EXT_ROW[j];
        return c;
    endfunction

    logic [SYN_W-1:0] cmp_mask;
    logic [SYN_W-1:0] syn_m;

    // Drop the extra row from every comparison while the spare is in repair.
    assign cmp_mask = {ext_en_i, {CHK_W{1'b1}}};
    assign syn_m    = syn_i & cmp_mask;
    assign syn_nz_o = |syn_m;

    // Single-bit comparators, one per codeword position.
    for (genvar j = 0; j < CODE_W; j++) begin : g_single
        localparam logic [SYN_W-1:0] COL = column(j);
        assign single_hit_o[j] = (syn_m == (COL & cmp_mask));
    end

    // Neighbour-pair comparators, including the data/check boundary pair.
    for (genvar k = 0; k < CODE_W - 1; k++) begin : g_pair
        localparam logic [SYN_W-1:0] PCOL = column(k) ^ column(k + 1);
        assign pair_hit_o[k] = (syn_m == (PCOL & cmp_mask));
    end

    // Spare-bit column; unreachable when the extra row is masked off.
    assign spare_hit_o = (syn_m == SPARE_COL);

endmodule

// File: rtl/sdaec_corrector.sv
`timescale 1ns/1ps
// Module: sdaec_corrector
// Turns comparator hits into a flip mask over the data bits and the three
// status flags.
// Assumes: data occupies codeword positions 0..DATA_W-1 and at most one
// comparator is active.
module sdaec_corrector #(
    parameter int DATA_W = sdaec_pkg::DATA_W,
    parameter int CODE_W = sdaec_pkg::CODE_W
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [CODE_W-1:0] single_hit_i,
    input  logic [CODE_W-2:0] pair_hit_i,
    input  logic              spare_hit_i,
    input  logic              syn_nz_i,
    output logic [DATA_W-1:0] data_o,
    output logic              single_o,
    output logic              pair_o,
    output logic              uncorr_o
);

    logic [DATA_W-1:0] flip;

    // A data bit flips on its own hit or on either pair that covers it.
    for (genvar p = 0; p < DATA_W; p++) begin : g_flip
        if (p == 0) begin : g_first
            assign flip[p] = single_hit_i[p] | pair_hit_i[p];
        end else begin : g_inner
            assign flip[p] = single_hit_i[p] | pair_hit_i[p] | pair_hit_i[p-1];
        end
    end

    // Apply the correction mask.
    assign data_o = data_i ^ flip;

    // Status: spare-bit hits count as single corrections.
    assign single_o = (|single_hit_i) | spare_hit_i;
    assign pair_o   = |pair_hit_i;
    assign uncorr_o = syn_nz_i & ~single_o & ~pair_o;

endmodule

// File: rtl/sdaec_codec.sv
`timescale 1ns/1ps
// Module: sdaec_codec
// Combinational single and neighbour-pair correcting codec with an optional
// extra check bit held in a spare memory column.
// Assumes: spare_used_i reflects repair status and is static during use.
module sdaec_codec #(
    parameter int DATA_W = sdaec_pkg::DATA_W,
    parameter int CHK_W  = sdaec_pkg::CHK_W,
    parameter logic [CHK_W-1:0][DATA_W-1:0] H_DATA = sdaec_pkg::H_DATA_DEF,
    parameter logic [DATA_W+CHK_W-1:0]      EXT_ROW = sdaec_pkg::EXT_ROW_DEF
) (
    input  logic [DATA_W-1:0]       enc_data_i,
    output logic [CHK_W-1:0]        enc_check_o,
    output logic                    enc_spare_o,
    input  logic [DATA_W+CHK_W-1:0] dec_code_i,
    input  logic                    dec_spare_i,
    input  logic                    spare_used_i,
    output logic [DATA_W-1:0]       dec_data_o,
    output logic                    dec_single_o,
    output logic                    dec_pair_o,
    output logic                    dec_uncorr_o
);

    localparam int CODE_W = DATA_W + CHK_W;
    localparam int SYN_W  = CHK_W + 1;

    logic [SYN_W-1:0]  syn;
    logic [CODE_W-1:0] single_hit;
    logic [CODE_W-2:0] pair_hit;
    logic              spare_hit;
    logic              syn_nz;

    sdaec_encoder #(
        .DATA_W (DATA_W), .CHK_W (CHK_W), .H_DATA (H_DATA), .EXT_ROW (EXT_ROW)
    ) u_enc (
        .data_i  (enc_data_i),
        .chk_o   (enc_check_o),
        .spare_o (enc_spare_o)
    );

    sdaec_syndrome #(
        .DATA_W (DATA_W), .CHK_W (CHK_W), .H_DATA (H_DATA), .EXT_ROW (EXT_ROW)
    ) u_syn (
        .code_i  (dec_code_i),
        .spare_i (dec_spare_i),
        .syn_o   (syn)
    );

    sdaec_matcher #(
        .DATA_W (DATA_W), .CHK_W (CHK_W), .H_DATA (H_DATA), .EXT_ROW (EXT_ROW)
    ) u_match (
        .syn_i        (syn),
        .ext_en_i     (~spare_used_i),
        .single_hit_o (single_hit),
        .pair_hit_o   (pair_hit),
        .spare_hit_o  (spare_hit),
        .syn_nz_o     (syn_nz)
    );

    sdaec_corrector #(
        .DATA_W (DATA_W), .CODE_W (CODE_W)
    ) u_corr (
        .data_i       (dec_code_i[DATA_W-1:0]),
        .single_hit_i (single_hit),
        .pair_hit_i   (pair_hit),
        .spare_hit_i  (spare_hit),
        .syn_nz_i     (syn_nz),
        .data_o       (dec_data_o),
        .single_o     (dec_single_o),
        .pair_o       (dec_pair_o),
        .uncorr_o     (dec_uncorr_o)
    );

endmodule

// File: rtl/sdaec_codec_chk.sv
`timescale 1ns/1ps
// Module: sdaec_codec_chk
// Property checker bound into sdaec_codec. The block has no clock, so the
// checks are immediate and run only once all decoder inputs are known.
module sdaec_codec_chk #(
    parameter int DATA_W = 16,
    parameter int CODE_W = 23
) (
    input logic [CODE_W-1:0] dec_code_i,
    input logic              dec_spare_i,
    input logic              spare_used_i,
    input logic [DATA_W-1:0] dec_data_o,
    input logic              dec_single_o,
    input logic              dec_pair_o,
    input logic              dec_uncorr_o,
    input logic [CODE_W-1:0] single_hit,
    input logic [CODE_W-2:0] pair_hit,
    input logic              spare_hit,
    input logic              syn_nz
);

    // Evaluate decoder properties whenever the inputs settle to known values.
    always_comb begin
        if (!$isunknown({dec_code_i, dec_spare_i, spare_used_i})) begin
            a_r9_one_match: assert ($onehot0({single_hit, pair_hit, spare_hit}))
                else $error("R9: more than one pattern matched");
            a_r10_flags_exclusive: assert ($countones({dec_single_o, dec_pair_o, dec_uncorr_o}) <= 1)
                else $error("R10: several flags high");
            a_r10_zero_syn_quiet: assert (syn_nz || !(dec_single_o || dec_pair_o || dec_uncorr_o))
                else $error("R10: flag raised on zero syndrome");
            a_r11_uncorr_passthru: assert (!dec_uncorr_o || dec_data_o == dec_code_i[DATA_W-1:0])
                else $error("R11: data altered on uncorrectable word");
            a_r2_single_flip_limit: assert (!dec_single_o || $countones(dec_data_o ^ dec_code_i[DATA_W-1:0]) <= 1)
                else $error("R2: single correction flipped more than one bit");
            a_r3_pair_flip_limit: assert (!dec_pair_o || $countones(dec_data_o ^ dec_code_i[DATA_W-1:0]) <= 2)
                else $error("R3: pair correction flipped more than two bits");
            a_r5_repair_no_spare_hit: assert (!spare_used_i || !spare_hit)
                else $error("R5: spare pattern matched while spare is in repair");
        end
    end

endmodule

bind sdaec_codec sdaec_codec_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_chk (
    .dec_code_i   (dec_code_i),
    .dec_spare_i  (dec_spare_i),
    .spare_used_i (spare_used_i),
    .dec_data_o   (dec_data_o),
    .dec_single_o (dec_single_o),
    .dec_pair_o   (dec_pair_o),
    .dec_uncorr_o (dec_uncorr_o),
    .single_hit   (single_hit),
    .pair_hit     (pair_hit),
    .spare_hit    (spare_hit),
    .syn_nz       (syn_nz)
);

// File: tb/sdaec_codec_tb.sv
`timescale 1ns/1ps
// Bench: exhaustive error sweeps over the default 16-bit configuration.
module sdaec_codec_tb;

    localparam int DW = 16;
    localparam int CW = 7;
    localparam int NW = DW + CW;

    // Row masks and extra row as stated in R1.
    localparam logic [15:0] ROW_MASK [CW] = '{16'hC429, 16'h2C91, 16'h9263,
                                             16'h095A, 16'hD986, 16'h3334, 16'h66CC};
    localparam logic [15:0] WORDS [4] = '{16'h0000, 16'hFFFF, 16'hA5C3, 16'h3C96};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [DW-1:0] enc_data_i;
    logic [CW-1:0] enc_check_o;
    logic          enc_spare_o;
    logic [NW-1:0] dec_code_i;
    logic          dec_spare_i;
    logic          spare_used_i;
    logic [DW-1:0] dec_data_o;
    logic          dec_single_o, dec_pair_o, dec_uncorr_o;

    int n_checks = 0;
    int n_fail   = 0;

    sdaec_codec u_dut (
        .enc_data_i   (enc_data_i),
        .enc_check_o  (enc_check_o),
        .enc_spare_o  (enc_spare_o),
        .dec_code_i   (dec_code_i),
        .dec_spare_i  (dec_spare_i),
        .spare_used_i (spare_used_i),
        .dec_data_o   (dec_data_o),
        .dec_single_o (dec_single_o),
        .dec_pair_o   (dec_pair_o),
        .dec_uncorr_o (dec_uncorr_o)
    );

    function automatic logic [CW-1:0] ref_chk(input logic [DW-1:0] d);
        logic [CW-1:0] c;
        for (int j = 0; j < CW; j++) c[j] = ^(d & ROW_MASK[j]);
        return c;
    endfunction

    function automatic logic ref_spare(input logic [DW-1:0] d, input logic [CW-1:0] c);
        return (^(d & 16'hAAAA)) ^ c[1] ^ c[3] ^ c[5];
    endfunction

    // Observed decoder result: {uncorr, pair, single, data}.
    function automatic logic [31:0] observed();
        return {13'd0, dec_uncorr_o, dec_pair_o, dec_single_o, dec_data_o};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive decoder inputs after a rising edge, return at the falling edge.
    task automatic apply(input logic [NW-1:0] c, input logic s, input logic u);
        @(posedge clk);
        #1;
        dec_code_i   = c;
        dec_spare_i  = s;
        spare_used_i = u;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(150000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int mis_en = 0;
        int mis_rep = 0;
        int unc_seen = 0;
        logic [31:0] exp_v, a0;
        enc_data_i   = '0;
        dec_code_i   = '0;
        dec_spare_i  = 1'b0;
        spare_used_i = 1'b0;
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: all-zero word encodes to zero and decodes quietly (R1).
        check(enc_check_o == '0 && enc_spare_o == 1'b0, "R1", "reset encode",
              {24'd0, enc_spare_o, enc_check_o}, 32'd0);
        check(observed() == 32'd0, "R1", "reset decode", observed(), 32'd0);

        for (int di = 0; di < 4; di++) begin
            logic [DW-1:0] d;
            logic [CW-1:0] c;
            logic          sp;
            logic [NW-1:0] cw;
            d  = WORDS[di];
            c  = ref_chk(d);
            sp = ref_spare(d, c);
            cw = {c, d};
            @(posedge clk);
            #1;
            enc_data_i = d;
            @(negedge clk);
            check(enc_check_o == c, "R1", "check bits", {25'd0, enc_check_o}, {25'd0, c});
            check(enc_spare_o == sp, "R1", "spare bit", {31'd0, enc_spare_o}, {31'd0, sp});

            for (int mode = 0; mode < 2; mode++) begin
                logic u;
                u = (mode == 1);
                // Clean word (R1).
                apply(cw, sp, u);
                exp_v = {16'd0, d};
                check(observed() == exp_v, "R1", "clean decode", observed(), exp_v);

                // Every single error (R2); spare toggled in repair mode (R5).
                for (int p = 0; p < NW; p++) begin
                    apply(cw ^ (NW'(1) << p), sp, u);
                    exp_v = {13'd0, 3'b001, d};
                    check(observed() == exp_v, "R2", "single error", observed(), exp_v);
                    if (u) begin
                        a0 = observed();
                        apply(cw ^ (NW'(1) << p), ~sp, u);
                        check(observed() == a0, "R5", "spare toggled on single", observed(), a0);
                    end
                end

                // Spare bit alone flipped (R4 when free, R5 when in repair).
                apply(cw, ~sp, u);
                if (!u) begin
                    exp_v = {13'd0, 3'b001, d};
                    check(observed() == exp_v, "R4", "spare bit error", observed(), exp_v);
                end else begin
                    exp_v = {16'd0, d};
                    check(observed() == exp_v, "R5", "spare ignored", observed(), exp_v);
                end

                // Every neighbouring pair, boundary pair 15/16 included (R3).
                for (int k = 0; k < NW - 1; k++) begin
                    apply(cw ^ (NW'(3) << k), sp, u);
                    exp_v = {13'd0, 3'b010, d};
                    check(observed() == exp_v, "R3", "adjacent pair", observed(), exp_v);
                    if (u) begin
                        a0 = observed();
                        apply(cw ^ (NW'(3) << k), ~sp, u);
                        check(observed() == a0, "R5", "spare toggled on pair", observed(), a0);
                    end
                end

                // Every non-adjacent pair (R6, R7, R8).
                for (int i = 0; i < NW; i++) begin
                    for (int j = i + 2; j < NW; j++) begin
                        logic [NW-1:0] bad;
                        bad = cw ^ (NW'(1) << i) ^ (NW'(1) << j);
                        apply(bad, sp, u);
                        check(dec_single_o | dec_pair_o | dec_uncorr_o, "R7",
                              "double error left silent", observed(), 32'h1_0000);
                        if (dec_uncorr_o) begin
                            if (!u) unc_seen++;
                            check(dec_data_o == bad[DW-1:0], "R6", "uncorrectable data kept",
                                  {16'd0, dec_data_o}, {16'd0, bad[DW-1:0]});
                        end else if (di == 0) begin
                            if (u) mis_rep++;
                            else   mis_en++;
                        end
                        if (u) begin
                            a0 = observed();
                            apply(bad, ~sp, u);
                            check(observed() == a0, "R5", "spare toggled on double", observed(), a0);
                        end
                    end
                end
            end
        end

        check(unc_seen > 0, "R6", "uncorrectable doubles seen", unc_seen, 1);
        check(mis_rep > 0, "R8", "repair-mode miscorrections present", mis_rep, 1);
        check(mis_en < mis_rep, "R8", "miscorrections reduced", mis_en, mis_rep);
        $display("Miscorrected non-adjacent doubles: spare free %0d, spare in repair %0d",
                 mis_en, mis_rep);
        finish_run();
    end

endmodule